// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This block is the shift and rotate slice of a 32-bit integer execute stage. It takes the 6-bit function code of a register-format instruction, the raw rs, rt, rd and shift-amount fields, and the two source operand values. In the same cycle it produces the shifted or rotated word, a register write strobe, and flags that tell the pipeline when the encoding was a no-op, a superscalar no-op or an execution hazard barrier. It has no clock and no state, so the issue stage can use it directly.

The unit performs left logical, right logical and right arithmetic shifts, and right rotates. The amount comes either from the instruction's shift-amount field or from the low five bits of the rs operand. A rotate has no function code of its own. It reuses the right-logical code and is selected by one spare bit: bit 0 of the rs field for the immediate form, and bit 0 of the shift-amount field for the register form. An all-zero left shift, where the rs, rt and rd fields are all zero, is recognised as a no-op. When the block cannot handle a function code it drops the write strobe and raises an unsupported flag. A single barrel network serves every operation. Left shifts are mapped onto it by reversing the bit order on the way in and on the way out.

Top module: `shf_unit`

## Requirements
- R1: Function code 0x00, unless it is a no-op encoding (see R7), returns rt_val shifted left by sa with zero fill and asserts the write strobe. This includes a shift by zero when the rd field is non-zero.
- R2: Function code 0x03 returns rt_val shifted right by sa, with every vacated bit set to bit 31 of rt_val.
- R3: Function code 0x02 with bit 0 of the rs field at 0 returns rt_val shifted right by sa with zero fill.
- R4: Function code 0x02 with bit 0 of the rs field at 1 returns rt_val rotated right by sa, equal to (x >> n) | (x << (32 - n)). An amount of 0 returns rt_val unchanged.
- R5: Function codes 0x04 (left logical) and 0x07 (right arithmetic) take their amount from bits 4:0 of rs_val. Bits 31:5 of rs_val have no effect on the result.
- R6: Function code 0x06 takes its amount from bits 4:0 of rs_val. It is a right logical shift when bit 0 of sa is 0 and a right rotate when that bit is 1.
- R7: Function code 0x00 with the rs, rt and rd fields all zero asserts nop_o, deasserts the write strobe and returns 0. Within that encoding, sa = 1 also asserts ssnop_o and sa = 3 also asserts ehb_o; every other sa value asserts neither.
- R8: Any function code other than 0x00, 0x02, 0x03, 0x04, 0x06 and 0x07 asserts unsupported_o. It also deasserts the write strobe and every no-op flag, and returns 0.
- R9: For every input, exactly one of wr_en_o, nop_o and unsupported_o is high. ssnop_o and ehb_o are never high without nop_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| func_i | input | 6 | Function code of the instruction |
| rs_fld_i | input | 5 | rs register field; bit 0 selects rotate for code 0x02 |
| rt_fld_i | input | 5 | rt register field |
| rd_fld_i | input | 5 | rd register field |
| sa_i | input | 5 | Shift-amount field; bit 0 selects rotate for code 0x06 |
| rs_val_i | input | 32 | rs operand; bits 4:0 give the variable amount |
| rt_val_i | input | 32 | rt operand, the value that is shifted |
| result_o | output | 32 | Shift or rotate result, 0 when no write |
| wr_en_o | output | 1 | Destination register write strobe |
| nop_o | output | 1 | Encoding is one of the no-op forms |
| ssnop_o | output | 1 | Superscalar no-op form |
| ehb_o | output | 1 | Execution hazard barrier form |
| unsupported_o | output | 1 | Function code not handled by this unit |

## Verification
The assertions are immediate checks inside combinational logic. They assume that every input is a known two-state value and that the default 32-bit width is in use. They hold for any value of the function, field and operand inputs. The stimulus keeps within these assumptions by driving every input to a defined value from the first cycle. It then covers whole input ranges: random operands, random field values and function codes drawn from both the handled and the unhandled set. Operand values with bit 31 set are included for the arithmetic and logical right shifts. Operand values with bits above bit 4 of rs_val set are included for the variable shifts.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    OP_LSL = 2'd0,
    OP_LSR = 2'd1,
    OP_ASR = 2'd2,
    OP_ROR = 2'd3
  } shf_op_e;

  localparam logic [5:0] FN_SHL_I = 6'h00;
  localparam logic [5:0] FN_SHR_I = 6'h02;
  localparam logic [5:0] FN_SAR_I = 6'h03;
  localparam logic [5:0] FN_SHL_R = 6'h04;
  localparam logic [5:0] FN_SHR_R = 6'h06;
  localparam logic [5:0] FN_SAR_R = 6'h07;

  localparam int unsigned SA_SUPER_NOP = 1;
  localparam int unsigned SA_BARRIER   = 3;

  typedef struct packed {
    shf_op_e op;
    logic    amt_from_reg;
    logic    wr_en;
    logic    nop;
    logic    ssnop;
    logic    ehb;
    logic    unsup;
  } shf_ctl_t;
endpackage

// File: rtl/shf_decode.sv
module shf_decode
  import shf_pkg::*;
#(
  parameter int unsigned FIELD_W = 5,
  parameter int unsigned SA_W    = 5
) (
  input  logic [5:0]         func_i,
  input  logic [FIELD_W-1:0] rs_fld_i,
  input  logic [FIELD_W-1:0] rt_fld_i,
  input  logic [FIELD_W-1:0] rd_fld_i,
  input  logic [SA_W-1:0]    sa_i,
  output shf_ctl_t           ctl_o
);
  logic zero_regs;
  assign zero_regs = (rs_fld_i == '0) && (rt_fld_i == '0) && (rd_fld_i == '0);

  always_comb begin
    ctl_o = '0;
    ctl_o.op = OP_LSL;
    unique case (func_i)
      FN_SHL_I: begin
        if (zero_regs) begin
          ctl_o.nop   = 1'b1;
          ctl_o.ssnop = (sa_i == SA_W'(SA_SUPER_NOP));
          ctl_o.ehb   = (sa_i == SA_W'(SA_BARRIER));
        end else begin
          ctl_o.wr_en = 1'b1;
        end
      end
      FN_SHR_I: begin
        ctl_o.wr_en = 1'b1;
        ctl_o.op    = rs_fld_i[0] ? OP_ROR : OP_LSR;
      end
      FN_SAR_I: begin
        ctl_o.wr_en = 1'b1;
        ctl_o.op    = OP_ASR;
      end
      FN_SHL_R: begin
        ctl_o.wr_en        = 1'b1;
        ctl_o.amt_from_reg = 1'b1;
      end
      FN_SHR_R: begin
        ctl_o.wr_en        = 1'b1;
        ctl_o.amt_from_reg = 1'b1;
        ctl_o.op           = sa_i[0] ? OP_ROR : OP_LSR;
      end
      FN_SAR_R: begin
        ctl_o.wr_en        = 1'b1;
        ctl_o.amt_from_reg = 1'b1;
        ctl_o.op           = OP_ASR;
      end
      default: ctl_o.unsup = 1'b1;
    endcase
  end

  always_comb begin
    // R9
    class_onehot_chk: assert ($countones({ctl_o.wr_en, ctl_o.nop, ctl_o.unsup}) == 1);
    // R9
    if (ctl_o.ssnop || ctl_o.ehb) begin
      flag_needs_nop_chk: assert (ctl_o.nop);
    end
    // R7
    if (ctl_o.nop) begin
      nop_only_zero_regs_chk: assert (func_i == FN_SHL_I && rd_fld_i == '0);
    end
  end
endmodule

// File: rtl/shf_amt_sel.sv
module shf_amt_sel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = $clog2(DATA_W)
) (
  input  logic              from_reg_i,
  input  logic [AMT_W-1:0]  sa_i,
  input  logic [DATA_W-1:0] rs_val_i,
  output logic [AMT_W-1:0]  amt_o
);
  // upper operand bits play no part in the amount
  logic unused_rs_hi;
  assign unused_rs_hi = ^rs_val_i[DATA_W-1:AMT_W];

  assign amt_o = from_reg_i ? rs_val_i[AMT_W-1:0] : sa_i;

  always_comb begin
    // R5
    if (from_reg_i) begin
      reg_amt_chk: assert (amt_o == rs_val_i[AMT_W-1:0]);
    end
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = $clog2(DATA_W)
) (
  input  shf_op_e           op_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic [DATA_W-1:0] x_i,
  output logic [DATA_W-1:0] y_o
);
  logic left, rot, sgn;
  assign left = (op_i == OP_LSL);
  assign rot  = (op_i == OP_ROR);
  assign sgn  = (op_i == OP_ASR) & x_i[DATA_W-1];

  logic [DATA_W-1:0] x_rev, out_rev;
  logic [DATA_W-1:0] stg [0:AMT_W];

  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign x_rev[b]   = x_i[DATA_W-1-b];
    assign out_rev[b] = stg[AMT_W][DATA_W-1-b];
  end

  assign stg[0] = left ? x_rev : x_i;

  // right-moving stages; rotate refills from the bits shifted out
  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    logic [STEP-1:0] fill;
    assign fill       = rot ? stg[k][STEP-1:0] : {STEP{sgn}};
    assign stg[k+1]   = amt_i[k] ? {fill, stg[k][DATA_W-1:STEP]} : stg[k];
  end

  assign y_o = left ? out_rev : stg[AMT_W];

  always_comb begin
    // R4
    if (op_i == OP_ROR && amt_i == '0) begin
      ror_zero_ident_chk: assert (y_o == x_i);
    end
    // R4
    if (op_i == OP_ROR) begin
      ror_popcount_chk: assert ($countones(y_o) == $countones(x_i));
    end
    // R2
    if (op_i == OP_ASR) begin
      asr_sign_keep_chk: assert (y_o[DATA_W-1] == x_i[DATA_W-1]);
    end
    // R3
    if (op_i == OP_LSR && amt_i != '0) begin
      lsr_msb_clear_chk: assert (!y_o[DATA_W-1]);
    end
    // R1
    if (op_i == OP_LSL && amt_i != '0) begin
      lsl_lsb_clear_chk: assert (!y_o[0]);
    end
  end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FIELD_W = 5
) (
  input  logic [5:0]                  func_i,
  input  logic [FIELD_W-1:0]          rs_fld_i,
  input  logic [FIELD_W-1:0]          rt_fld_i,
  input  logic [FIELD_W-1:0]          rd_fld_i,
  input  logic [$clog2(DATA_W)-1:0]   sa_i,
  input  logic [DATA_W-1:0]           rs_val_i,
  input  logic [DATA_W-1:0]           rt_val_i,
  output logic [DATA_W-1:0]           result_o,
  output logic                        wr_en_o,
  output logic                        nop_o,
  output logic                        ssnop_o,
  output logic                        ehb_o,
  output logic                        unsupported_o
);
  localparam int unsigned AMT_W = $clog2(DATA_W);

  shf_ctl_t          ctl;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] shifted;

  shf_decode #(.FIELD_W(FIELD_W), .SA_W(AMT_W)) u_decode (
    .func_i   (func_i),
    .rs_fld_i (rs_fld_i),
    .rt_fld_i (rt_fld_i),
    .rd_fld_i (rd_fld_i),
    .sa_i     (sa_i),
    .ctl_o    (ctl)
  );

  shf_amt_sel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_amt (
    .from_reg_i (ctl.amt_from_reg),
    .sa_i       (sa_i),
    .rs_val_i   (rs_val_i),
    .amt_o      (amt)
  );

  shf_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_barrel (
    .op_i  (ctl.op),
    .amt_i (amt),
    .x_i   (rt_val_i),
    .y_o   (shifted)
  );

  assign result_o      = ctl.wr_en ? shifted : '0;
  assign wr_en_o       = ctl.wr_en;
  assign nop_o         = ctl.nop;
  assign ssnop_o       = ctl.ssnop;
  assign ehb_o         = ctl.ehb;
  assign unsupported_o = ctl.unsup;

  always_comb begin
    // R8
    if (unsupported_o) begin
      unsup_quiet_chk: assert (result_o == '0 && !wr_en_o && !nop_o);
    end
    // R7
    if (nop_o) begin
      nop_quiet_chk: assert (result_o == '0 && !wr_en_o);
    end
  end
endmodule

// File: tb/shf_unit_bench.sv
module shf_unit_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [5:0]  func;
  logic [4:0]  rs_fld, rt_fld, rd_fld, sa;
  logic [31:0] rs_val, rt_val, result;
  logic        wr_en, nop, ssnop, ehb, unsup;

  shf_unit u_shf_unit (
    .func_i(func), .rs_fld_i(rs_fld), .rt_fld_i(rt_fld), .rd_fld_i(rd_fld),
    .sa_i(sa), .rs_val_i(rs_val), .rt_val_i(rt_val), .result_o(result),
    .wr_en_o(wr_en), .nop_o(nop), .ssnop_o(ssnop), .ehb_o(ehb),
    .unsupported_o(unsup)
  );

  typedef struct {
    logic [31:0] res;
    logic [4:0]  flags; // wr, nop, ssnop, ehb, unsup
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic logic [31:0] ror32(input logic [31:0] x, input logic [4:0] n);
    logic [63:0] t;
    t = {x, x} >> n;
    return t[31:0];
  endfunction

  function automatic exp_t model(input logic [5:0] f, input logic [4:0] rsf, rtf, rdf, s,
                                 input logic [31:0] rsv, rtv);
    exp_t e;
    logic [4:0] rv;
    rv = rsv[4:0];
    e.res = '0;
    e.flags = 5'b10000;
    case (f)
      6'h00: if (rsf == 0 && rtf == 0 && rdf == 0)
               e.flags = {1'b0, 1'b1, s == 5'd1, s == 5'd3, 1'b0};
             else e.res = rtv << s;
      6'h02: e.res = rsf[0] ? ror32(rtv, s) : rtv >> s;
      6'h03: e.res = $unsigned($signed(rtv) >>> s);
      6'h04: e.res = rtv << rv;
      6'h06: e.res = s[0] ? ror32(rtv, rv) : rtv >> rv;
      6'h07: e.res = $unsigned($signed(rtv) >>> rv);
      default: e.flags = 5'b00001;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [5:0] f, input logic [4:0] rsf, rtf, rdf, s,
                       input logic [31:0] rsv, rtv, input string tag);
    exp_t e;
    @(negedge clk);
    func = f; rs_fld = rsf; rt_fld = rtf; rd_fld = rdf; sa = s;
    rs_val = rsv; rt_val = rtv;
    e = model(f, rsf, rtf, rdf, s, rsv, rtv);
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (rst_ni && q.size() > 0) begin
      exp_t e;
      logic [4:0] act;
      e = q.pop_front();
      act = {wr_en, nop, ssnop, ehb, unsup};
      n_cmp++;
      if (result !== e.res || act !== e.flags) begin
        n_bad++;
        $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                 e.tag, result, act, e.res, e.flags);
      end
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    func = '0; rs_fld = '0; rt_fld = '0; rd_fld = '0; sa = '0;
    rs_val = '0; rt_val = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    // idle all-zero state is a plain NOP
    drive(6'h00, 0, 0, 0, 0, 32'h0, 32'h0, "R7 idle");
    drive(6'h00, 0, 3, 5, 4, 32'h0, 32'h8000_0001, "R1 sll");
    drive(6'h00, 0, 3, 7, 0, 32'h0, 32'hDEAD_BEEF, "R1 sll by 0");
    drive(6'h00, 0, 0, 0, 1, 32'h0, 32'hFFFF_FFFF, "R7 ssnop");
    drive(6'h00, 0, 0, 0, 3, 32'h0, 32'hFFFF_FFFF, "R7 ehb");
    drive(6'h00, 0, 0, 0, 7, 32'h0, 32'hFFFF_FFFF, "R7 plain nop");
    drive(6'h00, 0, 0, 4, 1, 32'h0, 32'h0000_0003, "R1 rd nonzero not ssnop");
    drive(6'h03, 0, 1, 2, 31, 32'h0, 32'h8000_0000, "R2 sra neg");
    drive(6'h03, 0, 1, 2, 4, 32'h0, 32'h7000_0000, "R2 sra pos");
    drive(6'h02, 2, 1, 2, 31, 32'h0, 32'h8000_0000, "R3 srl");
    drive(6'h02, 1, 1, 2, 4, 32'h0, 32'h1234_5678, "R4 rotr");
    drive(6'h02, 3, 1, 2, 0, 32'h0, 32'h1234_5678, "R4 rotr by 0");
    drive(6'h02, 1, 1, 2, 31, 32'h0, 32'h8000_0001, "R4 rotr by 31");
    drive(6'h04, 0, 1, 2, 0, 32'hFFFF_FFE3, 32'h0000_00F1, "R5 sllv high bits ignored");
    drive(6'h07, 0, 1, 2, 0, 32'h0000_0020, 32'h8765_4321, "R5 srav amount 0");
    drive(6'h07, 0, 1, 2, 0, 32'hABCD_0010, 32'h8765_4321, "R5 srav");
    drive(6'h06, 0, 1, 2, 0, 32'h0000_0008, 32'hF000_000F, "R6 srlv");
    drive(6'h06, 0, 1, 2, 1, 32'h0000_0008, 32'hF000_000F, "R6 rotrv");
    drive(6'h06, 0, 1, 2, 2, 32'hFFFF_FFE4, 32'hF000_000F, "R6 srlv sa bit0 clear");
    drive(6'h06, 0, 1, 2, 1, 32'h0000_0000, 32'hC3C3_5A5A, "R6 rotrv by 0");
    drive(6'h01, 0, 0, 0, 0, 32'h1, 32'hFFFF_FFFF, "R8 code 01");
    drive(6'h05, 1, 1, 1, 1, 32'h1, 32'hFFFF_FFFF, "R8 code 05");
    drive(6'h08, 0, 0, 0, 3, 32'h1, 32'hFFFF_FFFF, "R8 code 08");
    drive(6'h3F, 7, 7, 7, 7, 32'h1, 32'hFFFF_FFFF, "R8 code 3F");
    for (int i = 0; i < 400; i++) begin
      logic [5:0] f;
      case ($urandom_range(0, 7))
        0: f = 6'h00; 1: f = 6'h02; 2: f = 6'h03; 3: f = 6'h04;
        4: f = 6'h06; 5: f = 6'h07; 6: f = 6'($urandom);
        default: f = ($urandom_range(0, 1) == 1) ? 6'h00 : 6'h02;
      endcase
      drive(f, 5'($urandom_range(0, 3)), 5'($urandom_range(0, 2)),
            5'($urandom_range(0, 2)), 5'($urandom), $urandom, $urandom,
            "R9 random");
    end
    @(posedge clk);
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule